// File: doc/BRIEF.md
# Lane Alignment Configuration Checker

This block sits behind the per-lane 8b/10b decoders of a multi-lane converter link receiver. Once code group synchronization has been reached, each lane carries an alignment sequence of four multiframes. The block tracks those multiframes on every lane and pulls the link-parameter block out of the second multiframe. It decodes the fields, verifies the checksum, and compares each field against the locally programmed link settings. The inputs are assumed to be already deskewed, one octet per lane per clock. Lanes whose multiframe boundaries do not fall on the same clock are flagged.

The decoded received fields of every lane come out in the same packed layout as the local settings, so a status reader can compare the two directly. A per-lane, per-field mismatch mask shows which fields disagree. A single verdict (done, pass, fail) is produced once every lane has finished its sequence. The link may enter data mode only on pass. Dropping `sync_ok` restarts the whole check.

Top module: `ilas_cfg_chk`

## Requirements
- R1: With `sync_ok` high, a lane starts tracking at the first multiframe-open control octet (0x1C with the control flag set). Commas and other octets before it are ignored. Each of the four multiframes runs from an open octet to a close control octet (0x7C, flag set). A lane finishes when the edge sampling its fourth close octet occurs.
- R2: In the second multiframe, the octet right after the open octet must be the marker control octet 0x9C. It is followed by 14 configuration octets: 0 lane ID [4:0]; 1 lane count−1 [4:0]; 2 octets per frame−1; 3 frames per multiframe−1 [4:0]; 4 converters−1; 5 resolution−1 [4:0]; 6 subclass [7:5] and total bits per sample−1 [4:0]; 7 samples per converter per frame−1 [4:0]; 8 high-density flag [7]; 9 to 12 reserved; 13 checksum. Each field appears on `rx_cfg` in the cycle after the edge that sampled its octet.
- R3: The count fields (lanes, octets, frames, converters, resolution, total bits, samples) are presented as the received code plus one.
- R4: The checksum octet must equal the modulo-256 sum of configuration octets 0 to 12. The reserved octets and unused upper bits affect only this sum.
- R5: The mismatch mask of a lane is valid from the cycle after the edge that sampled its checksum octet. Bit 0 is lane ID, bit 1 lanes, bit 2 converters, bit 3 octets, bit 4 frames, bit 5 resolution, bit 6 total bits, bit 7 samples, bit 8 high density, bit 9 subclass, bit 10 checksum. Each bit is set when the received value differs from the local one.
- R6: Lane i's received lane ID is compared with bits [5i+4:5i] of `loc_lane_ids`.
- R7: `align_err[i]` becomes set, and stays set, in the cycle after any edge at which lane i's detection of a multiframe start differs from lane 0's.
- R8: The following are format errors: a missing marker, a close octet before the 14 configuration octets have arrived, or an open octet inside a multiframe. A format error forces fail. After a missing marker, the lane captures nothing, so its fields and mismatch bits stay zero.
- R9: One cycle after the edge at which the last lane finishes, `ilas_done` rises together with exactly one of `ilas_pass` / `ilas_fail`. Pass requires no mismatch bit, no alignment bit and no format error. The verdict stays frozen until `sync_ok` falls.
- R10: Once a lane has finished, further octets on it, including a new open octet, change no output.
- R11: `rst` high, or `sync_ok` low, at an edge clears every output at that edge and restarts tracking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_ok | input | 1 | Code group synchronization reached on all lanes |
| rx_octet | input | LANES*8 | Decoded octet per lane, lane i at [8i+7:8i] |
| rx_is_k | input | LANES | Control-character flag per lane |
| loc_lanes | input | 6 | Local lane count |
| loc_convs | input | 9 | Local converter count |
| loc_octs | input | 9 | Local octets per frame |
| loc_frames | input | 6 | Local frames per multiframe |
| loc_nbits | input | 6 | Local converter resolution |
| loc_ntot | input | 6 | Local total bits per sample |
| loc_spc | input | 6 | Local samples per converter per frame |
| loc_hd | input | 1 | Local high-density flag |
| loc_subclass | input | 3 | Local subclass |
| loc_lane_ids | input | LANES*5 | Expected lane ID per lane |
| rx_cfg | output | LANES*57 | Received fields per lane, MSB first: lane ID 5, lanes 6, converters 9, octets 9, frames 6, resolution 6, total bits 6, samples 6, HD 1, subclass 3 |
| mismatch | output | LANES*11 | Per-lane field mismatch mask (R5) |
| align_err | output | LANES | Per-lane multiframe misalignment, sticky |
| ilas_done | output | 1 | All lanes finished their sequence |
| ilas_pass | output | 1 | Sequence finished with no error |
| ilas_fail | output | 1 | Sequence finished with at least one error |

## Verification
Each field register updates one cycle after the edge that sampled its octet. The mismatch mask follows one cycle after the checksum edge. An alignment flag follows one cycle after the disagreeing start detection. The verdict follows one cycle after the final close octet. The bench records, from the stimulus it builds, the edge index of each checksum octet, each multiframe start and each final close octet. It then compares the verdict, mask and alignment outputs on every clock, half a period after each edge, against those indices plus one. Captured fields are compared once the sequence has ended, and every output is checked to be zero after each `sync_ok` drop.

// File: rtl/ilas_pkg.sv
package ilas_pkg;
  localparam logic [7:0] K_MF_OPEN  = 8'h1C;
  localparam logic [7:0] K_MF_CLOSE = 8'h7C;
  localparam logic [7:0] K_CFG_MARK = 8'h9C;
  localparam int CFG_OCTETS = 14;
  localparam int MM_W       = 11;

  localparam int MM_LID   = 0;
  localparam int MM_LANES = 1;
  localparam int MM_CONVS = 2;
  localparam int MM_OCTS  = 3;
  localparam int MM_FRM   = 4;
  localparam int MM_NBITS = 5;
  localparam int MM_NTOT  = 6;
  localparam int MM_SPC   = 7;
  localparam int MM_HD    = 8;
  localparam int MM_SUBC  = 9;
  localparam int MM_CSUM  = 10;

  typedef struct packed {
    logic [4:0] lane_id;
    logic [5:0] lanes;
    logic [8:0] convs;
    logic [8:0] octs;
    logic [5:0] frames;
    logic [5:0] nbits;
    logic [5:0] ntot;
    logic [5:0] spc;
    logic       hd;
    logic [2:0] subclass;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);
endpackage

// File: rtl/ilas_lane.sv
module ilas_lane
  import ilas_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sync_ok,
  input  logic [7:0] octet,
  input  logic       is_k,
  output logic       sof_stb,
  output cfg_t       rx,
  output logic       cfg_valid,
  output logic       cs_bad,
  output logic       fmt_err,
  output logic       done
);
  typedef enum logic [1:0] {L_WAIT, L_IN, L_GAP, L_DONE} st_t;
  localparam int POS_W = $clog2(CFG_OCTETS + 2);
  localparam logic [POS_W-1:0] POS_END = POS_W'(CFG_OCTETS + 1);
  localparam logic [POS_W-1:0] POS_CS  = POS_W'(CFG_OCTETS);

  st_t              st;
  logic [1:0]       mf;
  logic [POS_W-1:0] pos;
  logic [7:0]       sum;
  logic is_open, is_close, is_mark;

  assign is_open  = is_k && (octet == K_MF_OPEN);
  assign is_close = is_k && (octet == K_MF_CLOSE);
  assign is_mark  = is_k && (octet == K_CFG_MARK);
  assign sof_stb  = sync_ok && is_open && (st == L_WAIT || st == L_GAP);

  always_ff @(posedge clk) begin
    if (rst || !sync_ok) begin
      st        <= L_WAIT;
      mf        <= '0;
      pos       <= '0;
      sum       <= '0;
      rx        <= '0;
      cfg_valid <= 1'b0;
      cs_bad    <= 1'b0;
      fmt_err   <= 1'b0;
      done      <= 1'b0;
    end else begin
      case (st)
        L_WAIT: if (is_open) begin
          st  <= L_IN;
          mf  <= 2'd0;
          pos <= '0;
        end
        L_GAP: if (is_open) begin
          st  <= L_IN;
          mf  <= mf + 2'd1;
          pos <= '0;
        end
        L_IN: begin
          if (is_close) begin
            if (mf == 2'd1 && pos != POS_END) fmt_err <= 1'b1;
            if (mf == 2'd3) begin
              st   <= L_DONE;
              done <= 1'b1;
            end else begin
              st <= L_GAP;
            end
          end else if (is_open) begin
            fmt_err <= 1'b1;
          end else if (mf == 2'd1 && pos != POS_END) begin
            if (pos == '0) begin
              if (is_mark) pos <= POS_W'(1);
              else begin
                fmt_err <= 1'b1;
                pos     <= POS_END;
              end
            end else if (pos == POS_CS) begin
              cfg_valid <= 1'b1;
              cs_bad    <= (sum != octet);
              pos       <= POS_END;
            end else begin
              sum <= sum + octet;
              pos <= pos + POS_W'(1);
              case (pos)
                POS_W'(1): rx.lane_id <= octet[4:0];
                POS_W'(2): rx.lanes   <= {1'b0, octet[4:0]} + 6'd1;
                POS_W'(3): rx.octs    <= {1'b0, octet} + 9'd1;
                POS_W'(4): rx.frames  <= {1'b0, octet[4:0]} + 6'd1;
                POS_W'(5): rx.convs   <= {1'b0, octet} + 9'd1;
                POS_W'(6): rx.nbits   <= {1'b0, octet[4:0]} + 6'd1;
                POS_W'(7): begin
                  rx.ntot     <= {1'b0, octet[4:0]} + 6'd1;
                  rx.subclass <= octet[7:5];
                end
                POS_W'(8): rx.spc     <= {1'b0, octet[4:0]} + 6'd1;
                POS_W'(9): rx.hd      <= octet[7];
                default: ;
              endcase
            end
          end
        end
        default: ;
      endcase
    end
  end

  // R8
  fmt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(fmt_err) && $past(sync_ok) && !$past(rst)) |-> fmt_err);

  // R2
  done_needs_cfg_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> (cfg_valid || fmt_err));
endmodule

// File: rtl/ilas_cmp.sv
module ilas_cmp
  import ilas_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            sync_ok,
  input  cfg_t            rx,
  input  cfg_t            loc,
  input  logic            cfg_valid,
  input  logic            cs_bad,
  output logic [MM_W-1:0] mm
);
  logic [MM_W-1:0] diff;

  always_comb begin
    diff           = '0;
    diff[MM_LID]   = rx.lane_id  != loc.lane_id;
    diff[MM_LANES] = rx.lanes    != loc.lanes;
    diff[MM_CONVS] = rx.convs    != loc.convs;
    diff[MM_OCTS]  = rx.octs     != loc.octs;
    diff[MM_FRM]   = rx.frames   != loc.frames;
    diff[MM_NBITS] = rx.nbits    != loc.nbits;
    diff[MM_NTOT]  = rx.ntot     != loc.ntot;
    diff[MM_SPC]   = rx.spc      != loc.spc;
    diff[MM_HD]    = rx.hd       != loc.hd;
    diff[MM_SUBC]  = rx.subclass != loc.subclass;
    diff[MM_CSUM]  = cs_bad;
  end

  always_ff @(posedge clk) begin
    if (rst || !sync_ok) mm <= '0;
    else if (cfg_valid)  mm <= diff;
    else                 mm <= '0;
  end

  // R5
  mm_after_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (mm != '0) |-> cfg_valid);
endmodule

// File: rtl/ilas_align.sv
module ilas_align #(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sync_ok,
  input  logic [LANES-1:0] stb,
  output logic [LANES-1:0] mask
);
  always_ff @(posedge clk) begin
    if (rst || !sync_ok) mask <= '0;
    else begin
      for (int i = 0; i < LANES; i++)
        if (stb[i] != stb[0]) mask[i] <= 1'b1;
    end
  end

  // R7
  align_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    sync_ok |=> ((mask & $past(mask)) == $past(mask)));
endmodule

// File: rtl/ilas_cfg_chk.sv
module ilas_cfg_chk
  import ilas_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    sync_ok,
  input  logic [LANES*8-1:0]      rx_octet,
  input  logic [LANES-1:0]        rx_is_k,
  input  logic [5:0]              loc_lanes,
  input  logic [8:0]              loc_convs,
  input  logic [8:0]              loc_octs,
  input  logic [5:0]              loc_frames,
  input  logic [5:0]              loc_nbits,
  input  logic [5:0]              loc_ntot,
  input  logic [5:0]              loc_spc,
  input  logic                    loc_hd,
  input  logic [2:0]              loc_subclass,
  input  logic [LANES*5-1:0]      loc_lane_ids,
  output logic [LANES*CFG_W-1:0]  rx_cfg,
  output logic [LANES*MM_W-1:0]   mismatch,
  output logic [LANES-1:0]        align_err,
  output logic                    ilas_done,
  output logic                    ilas_pass,
  output logic                    ilas_fail
);
  logic [LANES-1:0] sof_vec, done_vec, fmt_vec;
  logic             err_any;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    cfg_t rx_l, loc_l;
    logic valid_l, csbad_l;

    always_comb begin
      loc_l          = '0;
      loc_l.lane_id  = loc_lane_ids[i*5 +: 5];
      loc_l.lanes    = loc_lanes;
      loc_l.convs    = loc_convs;
      loc_l.octs     = loc_octs;
      loc_l.frames   = loc_frames;
      loc_l.nbits    = loc_nbits;
      loc_l.ntot     = loc_ntot;
      loc_l.spc      = loc_spc;
      loc_l.hd       = loc_hd;
      loc_l.subclass = loc_subclass;
    end

    ilas_lane u_lane (
      .clk       (clk),
      .rst       (rst),
      .sync_ok   (sync_ok),
      .octet     (rx_octet[i*8 +: 8]),
      .is_k      (rx_is_k[i]),
      .sof_stb   (sof_vec[i]),
      .rx        (rx_l),
      .cfg_valid (valid_l),
      .cs_bad    (csbad_l),
      .fmt_err   (fmt_vec[i]),
      .done      (done_vec[i])
    );

    ilas_cmp u_cmp (
      .clk       (clk),
      .rst       (rst),
      .sync_ok   (sync_ok),
      .rx        (rx_l),
      .loc       (loc_l),
      .cfg_valid (valid_l),
      .cs_bad    (csbad_l),
      .mm        (mismatch[i*MM_W +: MM_W])
    );

    assign rx_cfg[i*CFG_W +: CFG_W] = rx_l;
  end

  ilas_align #(.LANES(LANES)) u_align (
    .clk     (clk),
    .rst     (rst),
    .sync_ok (sync_ok),
    .stb     (sof_vec),
    .mask    (align_err)
  );

  assign err_any = (|mismatch) | (|align_err) | (|fmt_vec);

  always_ff @(posedge clk) begin
    if (rst || !sync_ok) begin
      ilas_done <= 1'b0;
      ilas_pass <= 1'b0;
      ilas_fail <= 1'b0;
    end else if (!ilas_done && (&done_vec)) begin
      ilas_done <= 1'b1;
      ilas_pass <= !err_any;
      ilas_fail <= err_any;
    end
  end

  // R9
  verdict_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ilas_done && sync_ok) |=> (ilas_done && $stable(ilas_pass) && $stable(ilas_fail)));

  // R9
  verdict_excl_chk: assert property (@(posedge clk) disable iff (rst)
    ilas_done |-> (ilas_pass != ilas_fail));
endmodule

// File: tb/ilas_cfg_chk_tb.sv
`timescale 1ns/1ps
module ilas_cfg_chk_tb;
  localparam int LN = 4, CW = 57, MW = 11, C0 = 4, MFL = 20, SLEN = 100;

  logic clk = 1'b0, rst = 1'b1, sync_ok = 1'b0;
  logic [LN*8-1:0] rx_octet = '0;
  logic [LN-1:0]   rx_is_k = '0;
  logic [5:0] loc_lanes, loc_frames, loc_nbits, loc_ntot, loc_spc;
  logic [8:0] loc_convs, loc_octs;
  logic       loc_hd;
  logic [2:0] loc_subclass;
  logic [LN*5-1:0] loc_lane_ids;
  logic [LN*CW-1:0] rx_cfg;
  logic [LN*MW-1:0] mismatch;
  logic [LN-1:0]    align_err;
  logic ilas_done, ilas_pass, ilas_fail;

  always #4 clk = ~clk;

  ilas_cfg_chk #(.LANES(LN)) u_dut (
    .clk(clk), .rst(rst), .sync_ok(sync_ok), .rx_octet(rx_octet), .rx_is_k(rx_is_k),
    .loc_lanes(loc_lanes), .loc_convs(loc_convs), .loc_octs(loc_octs),
    .loc_frames(loc_frames), .loc_nbits(loc_nbits), .loc_ntot(loc_ntot),
    .loc_spc(loc_spc), .loc_hd(loc_hd), .loc_subclass(loc_subclass),
    .loc_lane_ids(loc_lane_ids), .rx_cfg(rx_cfg), .mismatch(mismatch),
    .align_err(align_err), .ilas_done(ilas_done), .ilas_pass(ilas_pass),
    .ilas_fail(ilas_fail));

  int nchk = 0, nfail = 0;
  logic [7:0] cb [LN][14];
  logic [8:0] strm [LN][SLEN];
  bit         sofm [LN][SLEN];
  int         cs_idx [LN];
  int         last_eof;
  logic [MW-1:0] mm_exp [LN];
  bit         exp_fail;
  logic [LN-1:0] amask;

  task automatic chk(input bit ok, input string msg);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s", msg);
    end
  endtask

  task automatic set_locals();
    loc_lanes = 6'd4; loc_octs = 9'd2; loc_frames = 6'd32; loc_convs = 9'd8;
    loc_nbits = 6'd16; loc_ntot = 6'd16; loc_spc = 6'd1; loc_hd = 1'b0;
    loc_subclass = 3'd1;
    for (int l = 0; l < LN; l++) loc_lane_ids[l*5 +: 5] = 5'(l);
  endtask

  task automatic mkcfg(input int l, input int lid);
    int s;
    cb[l][0] = 8'hE0 | 8'(lid); cb[l][1] = 8'h03; cb[l][2] = 8'h01;
    cb[l][3] = 8'h1F; cb[l][4] = 8'h07; cb[l][5] = 8'h0F; cb[l][6] = 8'h2F;
    cb[l][7] = 8'h00; cb[l][8] = 8'h00; cb[l][9] = 8'hA5; cb[l][10] = 8'h5A;
    cb[l][11] = 8'h11; cb[l][12] = 8'h22;
    s = 0;
    for (int j = 0; j < 13; j++) s += int'(cb[l][j]);
    cb[l][13] = 8'(s);
  endtask

  function automatic logic [CW-1:0] exp_cfg(input int l);
    return {cb[l][0][4:0], 6'(cb[l][1][4:0]) + 6'd1, 9'(cb[l][4]) + 9'd1,
            9'(cb[l][2]) + 9'd1, 6'(cb[l][3][4:0]) + 6'd1, 6'(cb[l][5][4:0]) + 6'd1,
            6'(cb[l][6][4:0]) + 6'd1, 6'(cb[l][7][4:0]) + 6'd1, cb[l][8][7], cb[l][6][7:5]};
  endfunction

  function automatic logic [MW-1:0] calc_mm(input int l);
    logic [MW-1:0] m;
    int s;
    m = '0;
    m[0]  = cb[l][0][4:0] != loc_lane_ids[l*5 +: 5];
    m[1]  = int'(cb[l][1][4:0]) + 1 != int'(loc_lanes);
    m[2]  = int'(cb[l][4]) + 1 != int'(loc_convs);
    m[3]  = int'(cb[l][2]) + 1 != int'(loc_octs);
    m[4]  = int'(cb[l][3][4:0]) + 1 != int'(loc_frames);
    m[5]  = int'(cb[l][5][4:0]) + 1 != int'(loc_nbits);
    m[6]  = int'(cb[l][6][4:0]) + 1 != int'(loc_ntot);
    m[7]  = int'(cb[l][7][4:0]) + 1 != int'(loc_spc);
    m[8]  = cb[l][8][7] != loc_hd;
    m[9]  = cb[l][6][7:5] != loc_subclass;
    s = 0;
    for (int j = 0; j < 13; j++) s += int'(cb[l][j]);
    m[10] = 8'(s) != cb[l][13];
    return m;
  endfunction

  task automatic build(input int dly_lane, input int nomark_lane);
    last_eof = 0;
    exp_fail = (dly_lane >= 0) || (nomark_lane >= 0);
    for (int l = 0; l < LN; l++) begin
      int base;
      base = C0 + ((l == dly_lane) ? 1 : 0);
      for (int e = 0; e < SLEN; e++) begin
        sofm[l][e] = 1'b0;
        strm[l][e] = (e < base) ? {1'b1, 8'hBC} : {1'b0, 8'(e * 3 + l)};
      end
      for (int m = 0; m < 4; m++) begin
        strm[l][base + m*MFL] = {1'b1, 8'h1C};
        sofm[l][base + m*MFL] = 1'b1;
        strm[l][base + m*MFL + MFL - 1] = {1'b1, 8'h7C};
      end
      strm[l][base + MFL + 1] = (l == nomark_lane) ? {1'b0, 8'h9C} : {1'b1, 8'h9C};
      for (int j = 0; j < 14; j++) strm[l][base + MFL + 2 + j] = {1'b0, cb[l][j]};
      strm[l][base + 4*MFL + 2] = {1'b1, 8'h1C};
      if (base + 4*MFL - 1 > last_eof) last_eof = base + 4*MFL - 1;
      if (l == nomark_lane) begin
        cs_idx[l] = -1;
        mm_exp[l] = '0;
      end else begin
        cs_idx[l] = base + MFL + 15;
        mm_exp[l] = calc_mm(l);
        if (mm_exp[l] != '0) exp_fail = 1'b1;
      end
    end
  endtask

  task automatic check_cycle(input int e);
    for (int l = 0; l < LN; l++) begin
      logic [MW-1:0] em;
      em = (cs_idx[l] >= 0 && e >= cs_idx[l] + 1) ? mm_exp[l] : '0;
      chk(mismatch[l*MW +: MW] == em, $sformatf("R5 cycle %0d lane %0d mismatch act %h exp %h",
          e, l, mismatch[l*MW +: MW], em));
      if (sofm[l][e] != sofm[0][e]) amask[l] = 1'b1;
    end
    chk(align_err == amask, $sformatf("R7 cycle %0d align act %b exp %b", e, align_err, amask));
    begin
      bit d;
      d = (e >= last_eof + 1);
      chk(ilas_done == d, $sformatf("R1 cycle %0d done act %b exp %b", e, ilas_done, d));
      chk(ilas_pass == (d && !exp_fail) && ilas_fail == (d && exp_fail),
          $sformatf("R9 cycle %0d pass/fail act %b%b exp %b%b", e, ilas_pass, ilas_fail,
          d && !exp_fail, d && exp_fail));
    end
  endtask

  task automatic check_clear(input string tag);
    chk(rx_cfg == '0 && mismatch == '0 && align_err == '0 && !ilas_done && !ilas_pass && !ilas_fail,
        $sformatf("%s cleared outputs act done%b pass%b fail%b mm %h al %b exp all zero",
        tag, ilas_done, ilas_pass, ilas_fail, mismatch, align_err));
  endtask

  task automatic run(input int dly_lane, input int nomark_lane);
    build(dly_lane, nomark_lane);
    amask = '0;
    @(negedge clk);
    sync_ok = 1'b0;
    repeat (2) @(negedge clk);
    check_clear("R11");
    for (int e = 0; e <= SLEN; e++) begin
      if (e > 0) begin
        @(negedge clk);
        check_cycle(e - 1);
      end
      if (e < SLEN) begin
        sync_ok = 1'b1;
        for (int l = 0; l < LN; l++) begin
          rx_octet[l*8 +: 8] = strm[l][e][7:0];
          rx_is_k[l] = strm[l][e][8];
        end
      end
    end
    for (int l = 0; l < LN; l++) begin
      logic [CW-1:0] ec;
      ec = (cs_idx[l] >= 0) ? exp_cfg(l) : '0;
      chk(rx_cfg[l*CW +: CW] == ec, $sformatf("R2 R3 R6 R8 lane %0d fields act %h exp %h",
          l, rx_cfg[l*CW +: CW], ec));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    set_locals();
    repeat (3) @(negedge clk);
    check_clear("R11 reset");
    rst = 1'b0;

    // R1 R2 R3 R10: clean sequence, reserved bytes nonzero, extra open octet after finish
    set_locals();
    for (int l = 0; l < LN; l++) mkcfg(l, l);
    run(-1, -1);
    chk(ilas_pass && align_err == '0, $sformatf("R10 after late open act pass%b al %b exp 1 0",
        ilas_pass, align_err));

    // R5: local octets and subclass differ
    set_locals();
    loc_octs = 9'd3; loc_subclass = 3'd2;
    for (int l = 0; l < LN; l++) mkcfg(l, l);
    run(-1, -1);

    // R4: corrupted checksum on lane 2
    set_locals();
    for (int l = 0; l < LN; l++) mkcfg(l, l);
    cb[2][13] = cb[2][13] ^ 8'h01;
    run(-1, -1);
    chk(mismatch[2*MW + 10] && ilas_fail, $sformatf("R4 checksum bit act %b fail %b exp 1 1",
        mismatch[2*MW + 10], ilas_fail));

    // R6: lanes 1 and 2 swapped
    set_locals();
    for (int l = 0; l < LN; l++) mkcfg(l, (l == 1) ? 2 : (l == 2) ? 1 : l);
    run(-1, -1);

    // R7: lane 3 one cycle late
    set_locals();
    for (int l = 0; l < LN; l++) mkcfg(l, l);
    run(3, -1);

    // R8: lane 1 marker sent without control flag
    set_locals();
    for (int l = 0; l < LN; l++) mkcfg(l, l);
    run(-1, 1);
    chk(ilas_fail && mismatch[1*MW +: MW] == '0, $sformatf("R8 act fail%b mm %h exp 1 0",
        ilas_fail, mismatch[1*MW +: MW]));

    @(negedge clk);
    sync_ok = 1'b0;
    @(negedge clk);
    check_clear("R11 final");

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule